// File: doc/BRIEF.md
# Free-Running 64-bit Timer with Compare Event

This block is a free-running 64-bit up-counter paired with a 64-bit comparator and a step register, reached through a small 32-bit register port. Software reads the count as two 32-bit words and arms the comparator to raise a timed event. The event can be one-shot, or periodic when the comparator moves forward by a programmed step on each match. One level-sensitive interrupt line reports the event.

The counter can be loaded only while it is stopped. The comparator fires whenever the count is at or past its value, so a deadline that has already passed still produces an event. The event flag is cleared by writing 1 to it. After a clear, the flag stays low until the comparator is rewritten or moves forward on its own. This prevents a second interrupt for the same deadline.

Top module: `gtc_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped, the comparator is disabled and `irq_o` is low.
- R2: While control bit 0 is set, the counter advances by exactly one per clock. While it is clear, the counter holds its value.
- R3: The count is one 64-bit value. When the low word wraps from 0xFFFFFFFF, the high word increments on the same clock.
- R4: While the counter is stopped, a write to offset 0x00 loads the low word and a write to 0x04 loads the high word. While it runs, writes to either offset are ignored.
- R5: When control bit 1 is set and the comparator is armed, the status flag (bit 0 at offset 0x0C) sets on the clock edge where the count is greater than or equal to the 64-bit comparator, not only where the two are equal. The flag is visible one clock after the condition holds.
- R6: While control bit 1 is clear, writes to the comparator words (low at 0x10, high at 0x14) never set the status flag.
- R7: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it unchanged. If a new event and a clear occur on the same clock, the event wins.
- R8: Once an event has fired, the comparator is disarmed. After a clear, the flag does not set again until the comparator is written or advanced by a step.
- R9: When control bit 3 is set, each event adds the 32-bit step register (offset 0x18) to the comparator, which then reads back the new value, and keeps the comparator armed.
- R10: `irq_o` is high exactly when the flag is set and both control bit 1 and control bit 2 are set.
- R11: The register offsets are fixed: the counter at 0x00 and 0x04, control at 0x08 (bits 3:0 read back, the rest read zero), status at 0x0C, the comparator at 0x10 and 0x14, and the step at 0x18. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for one clock |
| bus_addr_i | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
Faults in the count appear on the next read of either counter word. A missing carry or a missed increment shows up as a wrong value one clock after the edge where it happened.

A wrong armed state or a wrong compare shows on the status word and on `irq_o` one clock after the edge where the count reaches the comparator. It appears either as an event that never comes or as a flag that sets again after a clear.

A wrong step shows up as a comparator readback that does not match the number of events counted.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
   // byte offsets of the register words
   localparam int unsigned OFS_CNT  = 'h00;  // counter words at OFS_CNT + 4*h
   localparam int unsigned OFS_CTRL = 'h08;
   localparam int unsigned OFS_STAT = 'h0C;
   localparam int unsigned OFS_CMP  = 'h10;  // comparator words at OFS_CMP + 4*h
   localparam int unsigned OFS_STEP = 'h18;

   // control bit positions
   localparam int unsigned CB_RUN  = 0;
   localparam int unsigned CB_CMP  = 1;
   localparam int unsigned CB_IRQ  = 2;
   localparam int unsigned CB_AUTO = 3;
   localparam int unsigned CTRL_W  = 4;
endpackage

// File: rtl/gtc_counter.sv
module gtc_counter #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NW     = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_n_i,
   input  logic                 run_i,
   input  logic [NW-1:0]        wr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [NW*DATA_W-1:0] cnt_o
);
   localparam int unsigned CW = NW * DATA_W;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] load_v;

   for (genvar h = 0; h < NW; h++) begin : g_word
      assign load_v[h*DATA_W +: DATA_W] = wr_i[h] ? wdata_i : cnt_q[h*DATA_W +: DATA_W];
   end

   // a single wide adder: the carry crosses words on the same edge
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)   cnt_q <= '0;
      else if (run_i) cnt_q <= cnt_q + CW'(1);
      else            cnt_q <= load_v;
   end

   assign cnt_o = cnt_q;

   // R2
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      run_i |=> cnt_q == $past(cnt_q) + CW'(1));
   // R4
   cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!run_i && wr_i == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/gtc_compare.sv
module gtc_compare #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NW     = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_n_i,
   input  logic                 cmp_en_i,
   input  logic                 auto_en_i,
   input  logic [NW*DATA_W-1:0] cnt_i,
   input  logic [NW-1:0]        cmp_wr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   input  logic [DATA_W-1:0]    step_i,
   input  logic                 clr_i,
   output logic                 flag_o,
   output logic [NW*DATA_W-1:0] cmp_o
);
   localparam int unsigned CW = NW * DATA_W;

   logic [CW-1:0] cmp_q;
   logic [CW-1:0] cmp_load;
   logic          armed_q;
   logic          flag_q;
   logic          evt;

   for (genvar h = 0; h < NW; h++) begin : g_word
      assign cmp_load[h*DATA_W +: DATA_W] = cmp_wr_i[h] ? wdata_i : cmp_q[h*DATA_W +: DATA_W];
   end

   assign evt = cmp_en_i && armed_q && (cnt_i >= cmp_q);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cmp_q   <= '0;
         armed_q <= 1'b1;
      end else if (|cmp_wr_i) begin
         cmp_q   <= cmp_load;
         armed_q <= 1'b1;
      end else if (evt) begin
         if (auto_en_i) cmp_q <= cmp_q + CW'(step_i);
         else           armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)   flag_q <= 1'b0;
      else if (evt)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign cmp_o  = cmp_q;

   // R5
   ge_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (cmp_en_i && armed_q && cnt_i >= cmp_q) |=> flag_q);
   // R6
   off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!cmp_en_i && !flag_q) |=> !flag_q);
   // R8
   no_refire_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!armed_q && cmp_wr_i == '0 && !flag_q) |=> !flag_q);
   // R9
   auto_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (evt && auto_en_i && cmp_wr_i == '0) |=> cmp_q == $past(cmp_q) + CW'($past(step_i)));
endmodule

// File: rtl/gtc_timer.sv
module gtc_timer #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 64
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);
   import gtc_pkg::*;

   localparam int unsigned NW = CNT_W / DATA_W;

   if (CNT_W != 2 * DATA_W) begin : g_bad_width
      $error("gtc_timer: CNT_W must be twice DATA_W");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gtc_timer: ADDR_W must be at least 5");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] step_q;
   logic [NW-1:0]     cnt_wr;
   logic [NW-1:0]     cmp_wr;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cmp;
   logic              flag;
   logic              clr;

   for (genvar h = 0; h < NW; h++) begin : g_dec
      assign cnt_wr[h] = bus_wr_i && bus_addr_i == ADDR_W'(OFS_CNT + 4*h);
      assign cmp_wr[h] = bus_wr_i && bus_addr_i == ADDR_W'(OFS_CMP + 4*h);
   end
   assign clr = bus_wr_i && bus_addr_i == ADDR_W'(OFS_STAT) && bus_wdata_i[0];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         ctrl_q <= '0;
         step_q <= '0;
      end else if (bus_wr_i) begin
         if (bus_addr_i == ADDR_W'(OFS_CTRL)) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
         if (bus_addr_i == ADDR_W'(OFS_STEP)) step_q <= bus_wdata_i;
      end
   end

   gtc_counter #(.DATA_W(DATA_W), .NW(NW)) u_cnt (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .run_i   (ctrl_q[CB_RUN]),
      .wr_i    (cnt_wr),
      .wdata_i (bus_wdata_i),
      .cnt_o   (cnt)
   );

   gtc_compare #(.DATA_W(DATA_W), .NW(NW)) u_cmp (
      .clk_i     (clk_i),
      .rst_n_i   (rst_n_i),
      .cmp_en_i  (ctrl_q[CB_CMP]),
      .auto_en_i (ctrl_q[CB_AUTO]),
      .cnt_i     (cnt),
      .cmp_wr_i  (cmp_wr),
      .wdata_i   (bus_wdata_i),
      .step_i    (step_q),
      .clr_i     (clr),
      .flag_o    (flag),
      .cmp_o     (cmp)
   );

   always_comb begin
      bus_rdata_o = '0;
      for (int h = 0; h < NW; h++) begin
         if (bus_addr_i == ADDR_W'(OFS_CNT + 4*h)) bus_rdata_o = cnt[h*DATA_W +: DATA_W];
         if (bus_addr_i == ADDR_W'(OFS_CMP + 4*h)) bus_rdata_o = cmp[h*DATA_W +: DATA_W];
      end
      if (bus_addr_i == ADDR_W'(OFS_CTRL)) bus_rdata_o = DATA_W'(ctrl_q);
      if (bus_addr_i == ADDR_W'(OFS_STAT)) bus_rdata_o = DATA_W'(flag);
      if (bus_addr_i == ADDR_W'(OFS_STEP)) bus_rdata_o = step_q;
   end

   assign irq_o = flag && ctrl_q[CB_CMP] && ctrl_q[CB_IRQ];

   // R7
   w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (clr && !ctrl_q[CB_CMP]) |=> !flag);
endmodule

// File: tb/gtc_timer_test.sv
module gtc_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   gtc_timer uut (
      .clk_i(clk), .rst_n_i(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
   );

   // behavioural model built from the requirements
   logic [63:0] m_cnt, m_cmp;
   logic [3:0]  m_ctrl;
   logic [31:0] m_step;
   logic        m_flag, m_armed;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = '0; m_cmp = '0; m_ctrl = '0; m_step = '0; m_flag = 0; m_armed = 1;
      end else begin
         logic ev;
         logic [63:0] n_cnt, n_cmp;
         logic n_armed, n_flag;
         ev = m_ctrl[1] && m_armed && (m_cnt >= m_cmp);
         n_cnt = m_cnt; n_cmp = m_cmp; n_armed = m_armed; n_flag = m_flag;
         if (m_ctrl[0]) n_cnt = m_cnt + 64'd1;
         else if (bus_wr && bus_addr == 5'h00) n_cnt[31:0]  = bus_wdata;
         else if (bus_wr && bus_addr == 5'h04) n_cnt[63:32] = bus_wdata;
         if (bus_wr && (bus_addr == 5'h10 || bus_addr == 5'h14)) begin
            if (bus_addr == 5'h10) n_cmp[31:0] = bus_wdata; else n_cmp[63:32] = bus_wdata;
            n_armed = 1;
         end else if (ev) begin
            if (m_ctrl[3]) n_cmp = m_cmp + {32'd0, m_step}; else n_armed = 0;
         end
         if (ev) n_flag = 1;
         else if (bus_wr && bus_addr == 5'h0C && bus_wdata[0]) n_flag = 0;
         if (bus_wr && bus_addr == 5'h08) m_ctrl = bus_wdata[3:0];
         if (bus_wr && bus_addr == 5'h18) m_step = bus_wdata;
         m_cnt = n_cnt; m_cmp = n_cmp; m_armed = n_armed; m_flag = n_flag;
      end
   end

   function automatic logic [31:0] mread(logic [4:0] a);
      case (a)
         5'h00: return m_cnt[31:0];
         5'h04: return m_cnt[63:32];
         5'h08: return {28'd0, m_ctrl};
         5'h0C: return {31'd0, m_flag};
         5'h10: return m_cmp[31:0];
         5'h14: return m_cmp[63:32];
         5'h18: return m_step;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] next_deadline(logic [31:0] c, logic [31:0] step);
      return ((c - 1) / step + 1) * step;
   endfunction

   task automatic check(string req, logic [63:0] got, logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      if (!done) $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v, c;
      void'($urandom(32'd7341));
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state and R11 map
      for (int a = 0; a < 8; a++) begin
         rd(5'(a * 4), v); check("R1", v, 0);
      end
      check("R1 irq", irq, 0);

      // R4 load while stopped, R2/R3 run across the word boundary
      wr(5'h00, 32'hFFFF_FFFF);
      wr(5'h04, 32'd5);
      rd(5'h00, v); check("R4 lo", v, 32'hFFFF_FFFF);
      rd(5'h04, v); check("R4 hi", v, 5);
      wr(5'h08, 32'h1);
      wr(5'h00, 32'h0);          // ignored while running (R4)
      wr(5'h08, 32'h0);          // two increments in total (R2)
      rd(5'h00, v); check("R3 lo", v, 1);
      rd(5'h04, v); check("R3 hi", v, 6);
      idle(4);
      rd(5'h00, v); check("R2 hold", v, 1);
      rd(5'h08, v); check("R11 ctrl", v, 0);

      // R6 comparator writes while disabled never set the flag
      wr(5'h00, 32'd100); wr(5'h04, 32'd0);
      wr(5'h10, 32'd50);  wr(5'h14, 32'd0);
      idle(3);
      rd(5'h0C, v); check("R6", v, 0);

      // R5 greater-or-equal compare, R10 interrupt gating
      wr(5'h08, 32'h2);
      idle(1);
      rd(5'h0C, v); check("R5", v, 1);
      check("R10 masked", irq, 0);
      wr(5'h08, 32'h6);
      idle(1);
      check("R10 on", irq, 1);
      rd(5'h10, v); check("R9 no step", v, 50);

      // R7 write-one-to-clear, R8 no re-fire
      wr(5'h0C, 32'h0);
      idle(1);
      rd(5'h0C, v); check("R7 zero write", v, 1);
      wr(5'h0C, 32'h1);
      idle(3);
      rd(5'h0C, v); check("R8 stays clear", v, 0);
      check("R8 irq", irq, 0);
      wr(5'h10, 32'd60);
      idle(1);
      rd(5'h0C, v); check("R8 rearm", v, 1);

      // R9 periodic events
      wr(5'h08, 32'h0); wr(5'h0C, 32'h1);
      wr(5'h00, 32'd0); wr(5'h04, 32'd0);
      wr(5'h10, 32'd10); wr(5'h14, 32'd0);
      wr(5'h18, 32'd10);
      wr(5'h08, 32'hF);
      idle(35);
      wr(5'h08, 32'h0);
      idle(2);
      rd(5'h00, c);
      rd(5'h10, v); check("R9 step", v, next_deadline(c, 10));
      rd(5'h0C, v); check("R9 flag", v, 1);

      // random phase against the model (R2..R11)
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         bus_wr = 1'b0;
         #1;
         check("R11 read", bus_rdata, mread(bus_addr));
         check("R10 irq", irq, m_flag && m_ctrl[1] && m_ctrl[2]);
         bus_addr = 5'(($urandom % 8) * 4);
         if ($urandom % 3 == 0) begin
            bus_wr = 1'b1;
            case (bus_addr)
               5'h04, 5'h14: bus_wdata = ($urandom % 8 == 0) ? 32'd1 : 32'd0;
               5'h08: bus_wdata = $urandom;
               5'h0C: bus_wdata = $urandom % 2;
               5'h18: bus_wdata = $urandom % 12;
               default: bus_wdata = $urandom % 96;
            endcase
         end
      end
      @(negedge clk);
      bus_wr = 1'b0;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule